// File: doc/BRIEF.md
# Mixed-Width Write FIFO Sample Buffer

This block is the sample store of a data converter running in queue mode. A register-style bus writes samples into it over a 32-bit data path. A write may be one byte, one halfword or one word, and it carries a two-bit byte offset. Every slot holds one 16-bit sample. A word write places two samples at once. Byte writes build up one sample a lane at a time, and the sample counts only when both of its lanes are present.

A consume strobe stands in for the converter trigger and retires the oldest sample. A direct read port returns any slot by index and has no side effects. When the queue drains, a request flag is set. It is routed to the interrupt line or to the DMA request line, depending on the DMA enable. A DMA-done pulse clears it, and so does any accepted write.

Top module: `mixed_fifo_buf`

## Requirements
- R1: A word write (`wr_size`=2) is discarded when `wr_ptr` is odd; no pointer or level changes.
- R2: An accepted word write stores `wr_data[15:0]` at slot `wr_ptr` and `wr_data[31:16]` at slot `wr_ptr`+1. It raises `wr_ptr` by 2 and `level` by 2.
- R3: A byte write (`wr_size`=0) or halfword write (`wr_size`=1) whose `wr_ofs[1]` is 1 is discarded. An accepted halfword write stores `wr_data[15:0]` and advances `wr_ptr` by 1.
- R4: Any write is discarded when `level` equals DEPTH (16). A word write is also discarded when exactly one slot is free. `level` never exceeds DEPTH, and `full` is 1 exactly when `level` equals DEPTH.
- R5: In a byte write, `wr_ofs[0]`=0 writes `wr_data[7:0]` into the low byte of slot `wr_ptr`. `wr_ofs[0]`=1 writes `wr_data[15:8]` into its high byte.
- R6: Byte writes advance `wr_ptr` only once both lanes of the current slot have been written. The lanes may arrive in either order.
- R7: `rd_data` returns the slot selected by `rd_idx` and changes neither pointer.
- R8: While `buf_en` is 0, writes and consume strobes have no effect.
- R9: A consume that leaves the queue empty sets a request flag. With `dma_en`=0 the flag drives `irq`; with `dma_en`=1 it drives `dma_req` instead. `dma_done` clears the flag, and so does any accepted write.
- R10: After reset both pointers and `level` are 0, `empty` is 1, and `irq` and `dma_req` are 0.
- R11: A consume advances `rd_ptr` by one, modulo 16. When a write and a consume are accepted in the same cycle, `level` reflects both.
- R12: A consume while `level` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Buffer enable; gates writes and consumes |
| dma_en | input | 1 | Route the request to DMA instead of the interrupt |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word |
| wr_ofs | input | 2 | Byte offset of the access |
| wr_data | input | 32 | Write data, little-endian lanes |
| consume | input | 1 | Retire the oldest sample |
| dma_done | input | 1 | Clears the request flag |
| rd_idx | input | 4 | Slot index for direct read |
| rd_data | output | 16 | Contents of slot `rd_idx` |
| wr_ptr | output | 4 | Write pointer |
| rd_ptr | output | 4 | Read pointer |
| level | output | 5 | Number of stored samples |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| irq | output | 1 | Request, interrupt route |
| dma_req | output | 1 | Request, DMA route |

## Verification
The bench sends word writes at odd and even pointers. A design that ignores alignment would store two samples that straddle a pair, or advance the pointer by one. It sends byte lanes high-first and low-first. A design that commits early would advance after the first lane or mix lanes across slots. It drives a word write with one slot left and a halfword write when full, where a missing overflow check would wrap the level. It also pulses consume on an empty queue and alongside a write, where a wrong level update would drift, and it toggles the DMA route to catch a request that reaches both lines or fails to clear.

// File: rtl/mixed_fifo_buf.sv
module mixed_fifo_buf #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_en,
  input  logic                       dma_en,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_size,
  input  logic [1:0]                 wr_ofs,
  input  logic [31:0]                wr_data,
  input  logic                       consume,
  input  logic                       dma_done,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [15:0]                rd_data,
  output logic [$clog2(DEPTH)-1:0]   wr_ptr,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty,
  output logic                       irq,
  output logic                       dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          lo_got, hi_got, req_flag;

  wire is8  = wr_size == 2'd0;
  wire is16 = wr_size == 2'd1;
  wire is32 = wr_size == 2'd2;

  wire room1 = cnt < CW'(DEPTH);
  wire room2 = cnt <= CW'(DEPTH - 2);

  wire ok_small = wr_en & buf_en & (is8 | is16) & ~wr_ofs[1] & room1;
  wire ok32     = wr_en & buf_en & is32 & ~wp[0] & room2;
  wire byte_lo  = ok_small & is8 & ~wr_ofs[0];
  wire byte_hi  = ok_small & is8 &  wr_ofs[0];
  wire commit8  = (lo_got | byte_lo) & (hi_got | byte_hi);
  wire [1:0] adv = ok32 ? 2'd2 : (ok_small & (is16 | commit8)) ? 2'd1 : 2'd0;
  wire do_cons  = consume & buf_en & (cnt != '0);
  wire [CW-1:0] cnt_nxt = cnt + CW'(adv) - CW'(do_cons);

  always_ff @(posedge clk) begin
    if (ok32) begin
      mem[wp]           <= wr_data[15:0];
      mem[wp + AW'(1)]  <= wr_data[31:16];
    end else if (ok_small && is16) begin
      mem[wp] <= wr_data[15:0];
    end else if (byte_lo) begin
      mem[wp][7:0] <= wr_data[7:0];
    end else if (byte_hi) begin
      mem[wp][15:8] <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      lo_got   <= 1'b0;
      hi_got   <= 1'b0;
      req_flag <= 1'b0;
    end else begin
      wp  <= wp + AW'(adv);
      cnt <= cnt_nxt;
      if (do_cons) rp <= rp + AW'(1);
      if (ok32 || (ok_small && is16) || (ok_small && commit8)) begin
        lo_got <= 1'b0;
        hi_got <= 1'b0;
      end else begin
        if (byte_lo) lo_got <= 1'b1;
        if (byte_hi) hi_got <= 1'b1;
      end
      if (dma_done || adv != 2'd0)          req_flag <= 1'b0;
      else if (do_cons && cnt_nxt == '0)    req_flag <= 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];
  assign wr_ptr  = wp;
  assign rd_ptr  = rp;
  assign level   = cnt;
  assign full    = cnt == CW'(DEPTH);
  assign empty   = cnt == '0;
  assign irq     = req_flag & ~dma_en;
  assign dma_req = req_flag &  dma_en;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R4
  AST_ODD_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd2 && wp[0]) |=> wp == $past(wp)); // R1
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ok32 |=> wp == $past(wp) + AW'(2)); // R2
  AST_BIT1_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size != 2'd2 && wr_ofs[1]) |=> wp == $past(wp)); // R3
  AST_EMPTY_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cnt == '0) |=> rp == $past(rp)); // R12
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done) |=> !dma_req && !irq); // R9
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) !(irq && dma_req)); // R9
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> cnt == $past(cnt) && wp == $past(wp)); // R8
endmodule

// File: tb/sim_mixed_fifo_buf.sv
module sim_mixed_fifo_buf;
  logic clk = 0, rst_n = 0, buf_en = 1, dma_en = 0, wr_en = 0, consume = 0, dma_done = 0;
  logic [1:0] wr_size = 0, wr_ofs = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] rd_idx = 0;
  logic [15:0] rd_data;
  logic [3:0] wr_ptr, rd_ptr;
  logic [4:0] level;
  logic full, empty, irq, dma_req;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  mixed_fifo_buf u0 (.clk, .rst_n, .buf_en, .dma_en, .wr_en, .wr_size, .wr_ofs, .wr_data,
    .consume, .dma_done, .rd_idx, .rd_data, .wr_ptr, .rd_ptr, .level, .full, .empty,
    .irq, .dma_req);

  task automatic chk(input logic c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sz, input logic [1:0] ofs,
                     input logic [31:0] d, input logic cons);
    @(negedge clk);
    wr_en = we; wr_size = sz; wr_ofs = ofs; wr_data = d; consume = cons;
    @(negedge clk);
    wr_en = 0; consume = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [1:0] ofs, input logic [31:0] d);
    cyc(1, sz, ofs, d, 0);
  endtask

  task automatic pop();
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic slot(input int idx, input int exp, input string tag);
    rd_idx = 4'(idx); #1;
    chk(rd_data == 16'(exp), tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(wr_ptr == 0 && rd_ptr == 0 && level == 0, "R10 pointers", {wr_ptr, rd_ptr, level}, 0);
    chk(empty && !full && !irq && !dma_req, "R10 flags", {empty, full, irq, dma_req}, 4'b1000);
  endtask

  task automatic t_half_and_read();
    wr(1, 0, 32'h0000_1234);
    chk(wr_ptr == 1 && level == 1, "R3 halfword advance", wr_ptr, 1);
    slot(0, 16'h1234, "R7 read data");
    slot(0, 16'h1234, "R7 read repeat");
    chk(wr_ptr == 1 && rd_ptr == 0, "R7 pointers unchanged", {wr_ptr, rd_ptr}, 8'h10);
  endtask

  task automatic t_bit1();
    wr(1, 2, 32'h0000_9999);
    chk(wr_ptr == 1 && level == 1, "R3 halfword bit1 dropped", wr_ptr, 1);
    wr(0, 3, 32'h0000_9900);
    chk(wr_ptr == 1 && level == 1, "R3 byte bit1 dropped", wr_ptr, 1);
    slot(1, 16'h0000, "R3 no lane stored") ;
  endtask

  task automatic t_word();
    wr(2, 0, 32'hAAAA_5555);
    chk(wr_ptr == 1 && level == 1, "R1 odd pointer word dropped", wr_ptr, 1);
    wr(1, 0, 32'h0000_2222);
    wr(2, 0, 32'hBBBB_CCCC);
    chk(wr_ptr == 4 && level == 4, "R2 word step", wr_ptr, 4);
    slot(2, 16'hCCCC, "R2 low half");
    slot(3, 16'hBBBB, "R2 high half");
  endtask

  task automatic t_bytes();
    wr(0, 1, 32'h0000_AB00);
    chk(wr_ptr == 4 && level == 4, "R6 high lane alone holds", wr_ptr, 4);
    wr(0, 0, 32'h0000_00CD);
    chk(wr_ptr == 5 && level == 5, "R6 pair commits", wr_ptr, 5);
    slot(4, 16'hABCD, "R5 lanes high first");
    wr(0, 0, 32'h0000_0011);
    chk(wr_ptr == 5, "R6 low lane alone holds", wr_ptr, 5);
    wr(0, 1, 32'h0000_2200);
    chk(wr_ptr == 6, "R6 low first commits", wr_ptr, 6);
    slot(5, 16'h2211, "R5 lanes low first");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 15; i++) wr(1, 0, 32'(i));
    chk(level == 15 && wr_ptr == 15, "R4 fill 15", level, 15);
    pop();
    chk(level == 14 && rd_ptr == 1, "R11 pop advance", rd_ptr, 1);
    wr(1, 0, 32'h0000_00F0);
    chk(wr_ptr == 0 && level == 15, "R11 write pointer wraps", wr_ptr, 0);
    wr(2, 0, 32'h1111_2222);
    chk(level == 15 && wr_ptr == 0, "R4 word with one free dropped", level, 15);
    wr(1, 0, 32'h0000_0077);
    chk(level == 16 && full, "R4 full", level, 16);
    wr(1, 0, 32'h0000_0088);
    chk(level == 16 && wr_ptr == 1, "R4 write when full dropped", wr_ptr, 1);
    slot(0, 16'h0077, "R4 slot kept");
  endtask

  task automatic t_drain();
    pop();
    chk(level == 15 && rd_ptr == 2, "R11 pop from full", level, 15);
    cyc(1, 1, 0, 32'h0000_0055, 1);
    chk(level == 15 && wr_ptr == 2 && rd_ptr == 3, "R11 write and pop together", level, 15);
    for (int i = 0; i < 15; i++) pop();
    chk(empty && rd_ptr == 2, "R11 drained wraps", rd_ptr, 2);
    chk(irq && !dma_req, "R9 interrupt route", {irq, dma_req}, 2'b10);
    pop();
    chk(rd_ptr == 2 && level == 0, "R12 empty pop ignored", rd_ptr, 2);
    wr(1, 0, 32'h0000_0001);
    chk(!irq && level == 1, "R9 write clears flag", irq, 0);
  endtask

  task automatic t_dma();
    dma_en = 1;
    pop();
    chk(dma_req && !irq, "R9 DMA route", {irq, dma_req}, 2'b01);
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
    chk(!dma_req && !irq, "R9 done clears", dma_req, 0);
    dma_en = 0;
  endtask

  task automatic t_gate();
    buf_en = 0;
    wr(1, 0, 32'h0000_4444);
    chk(level == 0 && wr_ptr == 3, "R8 write gated", level, 0);
    buf_en = 1;
    wr(1, 0, 32'h0000_4444);
    buf_en = 0;
    pop();
    chk(level == 1 && rd_ptr == 3, "R8 consume gated", level, 1);
    buf_en = 1;
  endtask

  initial begin
    #(20 * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_half_and_read();
    t_bit1();
    t_word();
    t_bytes();
    t_overflow();
    t_drain();
    t_dma();
    t_gate();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule